// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block is the digital startup controller of a voltage-mode buck regulator. It stays idle until the undervoltage lockout reports a healthy supply. It then runs a fixed pre-start interval, counted in system clocks. During that interval the error amplifier is held preset just under the ramp valley, while the boost capacitor charges and the current-limit level settles. After the interval it raises a digital reference code one step at a time. Each step is held for a fixed number of switching-cycle ticks.

Code 0 stands for 0 V and code NUM_STEPS (24 by default) for full-scale reference. The code moves from 1 up to full scale, one step per CYC_PER_STEP ticks (64 by default). When the last step's ticks are used up, a one-clock completion pulse is raised and the code stays at full scale. A restart request or a loss of the supply-good level returns the block to idle at any time. The pre-start length DELAY_CLKS is a parameter. The total ramp time therefore follows from the tick rate: 24 × 64 ticks is about 5.1 ms at 300 kHz.

Top module: `softstart_seq`

## Requirements
- R1: After reset, and while uvlo_ok is low, ref_code is 0 and ea_preset, ss_active and ss_done are all 0.
- R2: From idle, with uvlo_ok high and restart_req low at a clock edge, the block enters the pre-start interval. From the next cycle, ea_preset and ss_active are 1 and ref_code is 0 for exactly DELAY_CLKS cycles.
- R3: In the cycle after the pre-start interval ends, ea_preset is 0, ss_active stays 1 and ref_code is 1.
- R4: While stepping, ref_code rises by exactly one each time CYC_PER_STEP sw_tick pulses have been counted in the current step. Clocks without sw_tick do not advance it. ref_code never exceeds NUM_STEPS.
- R5: sw_tick pulses that arrive in idle or during the pre-start interval are ignored. The first step still needs a full CYC_PER_STEP ticks.
- R6: When the ticks of the step at code NUM_STEPS are used up, ss_done is 1 for exactly one cycle and ss_active falls in that same cycle. ref_code then stays at NUM_STEPS, and later ticks change nothing.
- R7: restart_req high at a clock edge puts the block in idle from the next cycle (R1 outputs). It stays idle while restart_req is held, and starts a new pre-start interval when restart_req is released.
- R8: uvlo_ok low at a clock edge has the same effect as R7, from any state.
- R9: An abort (R7 or R8) on the same edge as the final tick of the last step wins: no ss_done pulse, and ref_code returns to 0.
- R10: rst_n low forces all outputs to their R1 values at once, without a clock edge. After rst_n rises, the block ignores its inputs for two clock edges and acts from the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uvlo_ok | input | 1 | Supply above the lockout threshold |
| sw_tick | input | 1 | One-clock pulse per switching cycle |
| restart_req | input | 1 | Request to abandon the sequence and start over |
| ref_code | output | $clog2(NUM_STEPS+1) | Digital reference code, 0 to NUM_STEPS |
| ea_preset | output | 1 | Hold the error amplifier just below the ramp valley |
| ss_active | output | 1 | Pre-start interval or stepping in progress |
| ss_done | output | 1 | One-clock pulse when the last step completes |

## Verification
The assertions watch invariants that hold on every cycle:
- ref_code only ever moves up by one or back to zero, and stays within range.
- A step after the first only advances on a tick.
- The preset flag implies code zero with the sequence active.
- The done pulse is one cycle wide and occurs only at full scale.
- Any abort empties the outputs on the next cycle.

Other behaviours need the bench's scenarios, driven against a behavioural reference model on every clock:
- the exact pre-start length;
- the exact tick count per step;
- ticks ignored before stepping;
- the abort racing the final tick;
- the two-edge reset release.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    SS_IDLE  = 2'd0,
    SS_DELAY = 2'd1,
    SS_STEP  = 2'd2,
    SS_DONE  = 2'd3
  } ss_state_e;
endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_s_n = hold_q;
endmodule

// File: rtl/ss_cycle_counter.sv
// Counts enabled cycles modulo LIMIT; last_o flags the enabled cycle that wraps.
module ss_cycle_counter #(
  parameter int LIMIT = 64,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign last_o = en_i && (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ss_ref_stepper.sv
// Reference code register: clear wins over load-one, load-one over increment.
module ss_ref_stepper #(
  parameter int REF_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_i,
  input  logic             one_i,
  input  logic             inc_i,
  output logic [REF_W-1:0] ref_o
);
  logic [REF_W-1:0] code_q;
  logic [REF_W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (zero_i) begin
      code_d = '0;
    end else if (one_i) begin
      code_d = REF_W'(1);
    end else if (inc_i) begin
      code_d = code_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_d;
    end
  end

  assign ref_o = code_q;
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int NUM_STEPS    = 24,
  parameter int CYC_PER_STEP = 64,
  parameter int DELAY_CLKS   = 40000,
  localparam int REF_W = $clog2(NUM_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo_ok,
  input  logic             sw_tick,
  input  logic             restart_req,
  output logic [REF_W-1:0] ref_code,
  output logic             ea_preset,
  output logic             ss_active,
  output logic             ss_done
);
  import ss_pkg::*;

  localparam logic [REF_W-1:0] FULL_CODE = REF_W'(NUM_STEPS);

  logic      rst_s_n;
  ss_state_e state_q;
  ss_state_e state_d;
  logic      done_q;
  logic      done_d;
  logic      abort;
  logic      dly_last;
  logic      step_last;
  logic      at_full;
  logic      ref_zero;
  logic      ref_one;
  logic      ref_inc;

  ss_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  ss_cycle_counter #(.LIMIT(DELAY_CLKS)) u_dly_cnt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr_i  (abort || (state_q != SS_DELAY)),
    .en_i   (state_q == SS_DELAY),
    .last_o (dly_last)
  );

  ss_cycle_counter #(.LIMIT(CYC_PER_STEP)) u_tick_cnt (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr_i  (abort || (state_q != SS_STEP)),
    .en_i   (sw_tick && (state_q == SS_STEP)),
    .last_o (step_last)
  );

  ss_ref_stepper #(.REF_W(REF_W)) u_ref (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .zero_i (ref_zero),
    .one_i  (ref_one),
    .inc_i  (ref_inc),
    .ref_o  (ref_code)
  );

  assign abort   = !uvlo_ok || restart_req;
  assign at_full = (ref_code == FULL_CODE);

  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    ref_zero = 1'b0;
    ref_one  = 1'b0;
    ref_inc  = 1'b0;
    if (abort) begin
      state_d  = SS_IDLE;
      ref_zero = 1'b1;
    end else begin
      unique case (state_q)
        SS_IDLE: begin
          state_d = SS_DELAY;
        end
        SS_DELAY: begin
          if (dly_last) begin
            state_d = SS_STEP;
            ref_one = 1'b1;
          end
        end
        SS_STEP: begin
          if (step_last) begin
            if (at_full) begin
              state_d = SS_DONE;
              done_d  = 1'b1;
            end else begin
              ref_inc = 1'b1;
            end
          end
        end
        SS_DONE: begin
          state_d = SS_DONE;
        end
        default: begin
          state_d  = SS_IDLE;
          ref_zero = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= SS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign ea_preset = (state_q == SS_DELAY);
  assign ss_active = (state_q == SS_DELAY) || (state_q == SS_STEP);
  assign ss_done   = done_q;
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
  parameter int NUM_STEPS = 24,
  parameter int REF_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uvlo_ok,
  input logic             sw_tick,
  input logic             restart_req,
  input logic [REF_W-1:0] ref_code,
  input logic             ea_preset,
  input logic             ss_active,
  input logic             ss_done
);
  localparam logic [REF_W-1:0] FULL_CODE = REF_W'(NUM_STEPS);

  // R4: code never exceeds full scale
  p_ref_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code <= FULL_CODE);

  // R4: code only climbs by one or drops to zero
  p_ref_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code != $past(ref_code)) |->
      ((ref_code == $past(ref_code) + 1'b1) || (ref_code == '0)));

  // R4: after the first step, an increase needs a tick on the edge that made it
  p_tick_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ref_code > $past(ref_code)) && ($past(ref_code) != '0)) |-> $past(sw_tick));

  // R2: preset only with code zero and the sequence active
  p_preset_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ea_preset |-> ((ref_code == '0) && ss_active));

  // R3: the preset ending without an abort leaves code one
  p_first_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ea_preset) && ss_active) |-> (ref_code == REF_W'(1)));

  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |=> !ss_done);

  // R6: done only at full scale, with active already low
  p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> ((ref_code == FULL_CODE) && !ss_active && !ea_preset));

  // R7/R8: any abort empties the outputs on the next cycle
  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req || !uvlo_ok) |=>
      ((ref_code == '0) && !ss_active && !ss_done && !ea_preset));
endmodule

bind softstart_seq softstart_seq_chk #(.NUM_STEPS(NUM_STEPS), .REF_W(REF_W)) u_chk (.*);

// File: tb/softstart_seq_tb_top.sv
module softstart_seq_tb_top;
  localparam int NSTEP = 24;
  localparam int NCYC  = 64;
  localparam int DLY   = 40;

  logic       clk;
  logic       rst_n;
  logic       uvlo_ok;
  logic       sw_tick;
  logic       restart_req;
  logic [4:0] ref_code;
  logic       ea_preset;
  logic       ss_active;
  logic       ss_done;

  int total;
  int bad;
  bit finished;

  softstart_seq #(.NUM_STEPS(NSTEP), .CYC_PER_STEP(NCYC), .DELAY_CLKS(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .sw_tick(sw_tick),
    .restart_req(restart_req), .ref_code(ref_code), .ea_preset(ea_preset),
    .ss_active(ss_active), .ss_done(ss_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model
  int m_rs, m_ph, m_ref, m_dc, m_tc;
  bit m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_ph = 0; m_ref = 0; m_dc = 0; m_tc = 0; m_done = 0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      m_done = 0;
      if (!uvlo_ok || restart_req) begin
        m_ph = 0; m_ref = 0; m_dc = 0; m_tc = 0;
      end else begin
        case (m_ph)
          0: begin m_ph = 1; m_dc = 0; end
          1: begin
            m_dc++;
            if (m_dc == DLY) begin m_ph = 2; m_ref = 1; m_tc = 0; end
          end
          2: if (sw_tick) begin
            m_tc++;
            if (m_tc == NCYC) begin
              m_tc = 0;
              if (m_ref == NSTEP) begin m_ph = 3; m_done = 1; end
              else m_ref++;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (ref_code != 5'(m_ref) || ea_preset != (m_ph == 1) ||
          ss_active != (m_ph == 1 || m_ph == 2) || ss_done != m_done) begin
        bad++;
        $display("FAIL R4 model compare t=%0t: ref=%0d/%0d preset=%0b/%0b active=%0b/%0b done=%0b/%0b",
                 $time, ref_code, m_ref, ea_preset, (m_ph == 1), ss_active,
                 (m_ph == 1 || m_ph == 2), ss_done, m_done);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, {ref_code, ea_preset, ss_active, ss_done}, 0);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sw_tick = 1'b1;
      @(negedge clk); sw_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wait_delay();
    for (int i = 0; i < DLY; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int pc;
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; uvlo_ok = 1'b0; sw_tick = 1'b0; restart_req = 1'b0;
    #1;
    chk_idle("R10 async reset at time zero");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_idle("R1 idle after reset, uvlo low");
    ticks(3, 1);
    chk_idle("R1 ticks while uvlo low");

    // R2: start, count preset cycles
    uvlo_ok = 1'b1;
    @(negedge clk);
    chk("R2 preset after uvlo", ea_preset, 1);
    chk("R2 active during delay", ss_active, 1);
    pc = 0;
    while (ea_preset && pc < DLY + 5) begin
      pc++;
      sw_tick = pc[0];            // R5: ticks during delay are ignored
      @(negedge clk);
    end
    sw_tick = 1'b0;
    chk("R2 delay length", pc, DLY);
    chk("R3 first code", ref_code, 1);
    chk("R3 active stepping", ss_active, 1);

    // R4/R5: first step needs full NCYC ticks
    ticks(NCYC - 1, 1);
    chk("R5 step one not shortened", ref_code, 1);
    ticks(1, 0);
    chk("R4 advance after NCYC ticks", ref_code, 2);
    repeat (20) @(negedge clk);
    chk("R4 no advance without ticks", ref_code, 2);

    ticks((NSTEP - 1) * NCYC - 1, 0);
    chk("R4 full code before last tick", ref_code, NSTEP);
    chk("R6 no done yet", ss_done, 0);
    @(negedge clk); sw_tick = 1'b1;
    @(negedge clk); sw_tick = 1'b0;
    chk("R6 done pulse", ss_done, 1);
    chk("R6 active low with done", ss_active, 0);
    @(negedge clk);
    chk("R6 done one cycle", ss_done, 0);
    ticks(NCYC + 3, 0);
    chk("R6 code held at full", ref_code, NSTEP);
    chk("R6 no second done", ss_done, 0);

    // R7: restart from done
    restart_req = 1'b1;
    @(negedge clk);
    chk_idle("R7 restart to idle");
    ticks(4, 0);
    chk_idle("R7 idle while restart held");
    restart_req = 1'b0;
    @(negedge clk);
    chk("R7 restart release starts delay", ea_preset, 1);

    // R8: uvlo loss while stepping
    wait_delay();
    ticks(2 * NCYC + 5, 0);
    chk("R8 precondition code", ref_code, 3);
    uvlo_ok = 1'b0;
    @(negedge clk);
    chk_idle("R8 uvlo loss to idle");
    uvlo_ok = 1'b1;
    @(negedge clk);
    chk("R8 restart after uvlo return", ea_preset, 1);

    // R9: abort racing the final tick
    wait_delay();
    ticks(NSTEP * NCYC - 1, 0);
    chk("R9 at last tick", ref_code, NSTEP);
    @(negedge clk); sw_tick = 1'b1; restart_req = 1'b1;
    @(negedge clk); sw_tick = 1'b0;
    chk("R9 no done on abort", ss_done, 0);
    chk("R9 code zero on abort", ref_code, 0);
    restart_req = 1'b0;

    // R10: async reset mid-sequence and delayed release
    wait_delay();
    ticks(10, 0);
    #2 rst_n = 1'b0;
    #1 chk_idle("R10 async reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 held edge 1", ea_preset, 0);
    @(negedge clk);
    chk("R10 held edge 2", ea_preset, 0);
    @(negedge clk);
    chk("R10 acts on edge 3", ea_preset, 1);
    repeat (5) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule